// File: doc/BRIEF.md
# Burst-Counting Synchronous Data SRAM

This block is a synchronous, single-port data memory with a built-in two-bit burst address counter. Its array is behavioural, with a parameterised depth and a 64-bit word. An active-low address strobe captures an external word address and starts an access. After that, an active-low count-enable steps the two low address bits through a four-beat burst. When count-enable is high, the access is suspended on its current address. A mode pin picks the beat order, which is either a wrapping increment or an XOR of the start value with the beat index. The upper address bits never change within a burst, so the burst stays inside its aligned four-word group.

Writes are captured on the rising clock edge. The high and low 32-bit halves of the word each have their own active-low write enable. Read data is registered and appears one clock after the address is used. The output-enable is combinational: it gates a data output, and a separate drive flag stands in for a tri-state bus. A standby input deselects the device. While standby is high, no address is used, nothing is written and the output is not driven.

Top module: `burst_sram`

## Requirements
- R1: With `standby` low, `adr_stb_n` sampled low on a rising edge loads `addr` as the access address, and that address is read or written in the same cycle.
- R2: With `adr_stb_n` high, `cnt_en_n` low and an access in progress, the access moves to the next burst address.
- R3: With `adr_stb_n` and `cnt_en_n` both high and an access in progress, the address is held. A read repeats the same word.
- R4: With `burst_ilv` = 0, the low two address bits of beat k are (start + k) mod 4, for example 01, 10, 11, 00.
- R5: With `burst_ilv` = 1, the low two address bits of beat k are start XOR k, for example 10, 11, 00, 01.
- R6: `wr_en_n[1]` low writes `wdata[63:32]` and `wr_en_n[0]` low writes `wdata[31:0]`. The half whose enable is high keeps its old contents. A cycle with either enable low is a write cycle.
- R7: `dq_oe` follows `oe_n` in the same cycle, with no clock. Data is driven only while `oe_n` is low after a read cycle.
- R8: Read data of the address used in cycle n is on `dq_out` with `dq_oe` = 1 in cycle n+1, provided the drive conditions hold.
- R9: While `standby` is high, no access takes place: no write, no load and no advance, and `dq_oe` is 0.
- R10: Advancing past the fourth beat wraps inside the same aligned four-word group. The upper address bits never change.
- R11: `dq_oe` is 0 in every cycle in which either write enable is low.
- R12: After reset, `dq_oe` is 0 and no access is in progress. `cnt_en_n` low without a prior strobe does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Deselects the device while high |
| adr_stb_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Burst advance, active low |
| burst_ilv | input | 1 | Beat order: 0 wrapping increment, 1 XOR |
| addr | input | AW (8) | External word address |
| wr_en_n | input | 2 | Write enables, active low; bit 1 high half, bit 0 low half |
| wdata | input | 64 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 64 | Read data; zero when not driven |
| dq_oe | output | 1 | High while `dq_out` is driven |

## Verification
The hardest cases to reach are those where several controls overlap inside one burst. Examples are a suspended beat that is then advanced across the group wrap, and a write issued on the cycle right after a read while `oe_n` is still low. The bench first fills every word with an address-tagged pattern, so each returned word shows which address was used. It then runs directed bursts that place suspend, wrap, half-word writes and standby on specific beats. Last, a long seeded random run changes strobe, count-enable, write enables, output-enable and standby cycle by cycle against a bench-side model of the burst order.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   // two-bit beat field: four beats per burst
   localparam int unsigned BEAT_W = 2;

   // low address bits for a given beat of a burst
   function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                  input logic [BEAT_W-1:0] beat,
                                                  input logic              ilv);
      return ilv ? (start ^ beat) : (start + beat);
   endfunction
endpackage

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
   import bsram_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          standby,
   input  logic          stb_n,
   input  logic          cnt_n,
   input  logic          ilv,
   input  logic [AW-1:0] ext_addr,
   output logic          acc_vld,
   output logic [AW-1:0] acc_addr
);
   localparam int unsigned HW = AW - BEAT_W;

   logic [HW-1:0]     hi_q, hi_d;
   logic [BEAT_W-1:0] start_q, start_d, beat_q, beat_d;
   logic              act_q;
   logic              load, adv, susp;

   always_comb begin
      load    = ~standby & ~stb_n;
      adv     = ~standby & stb_n & ~cnt_n & act_q;
      susp    = ~standby & stb_n & cnt_n & act_q;
      hi_d    = load ? ext_addr[AW-1:BEAT_W] : hi_q;
      start_d = load ? ext_addr[BEAT_W-1:0] : start_q;
      if (load)
         beat_d = '0;
      else if (adv)
         beat_d = beat_q + 1'b1;
      else
         beat_d = beat_q;
      acc_vld  = load | adv | susp;
      acc_addr = {hi_d, beat_low(start_d, beat_d, ilv)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         hi_q    <= '0;
         start_q <= '0;
         beat_q  <= '0;
      end else begin
         act_q <= ~standby & (load | act_q);
         if (acc_vld) begin
            hi_q    <= hi_d;
            start_q <= start_d;
            beat_q  <= beat_d;
         end
      end
   end

   AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> acc_addr[AW-1:BEAT_W] == $past(acc_addr[AW-1:BEAT_W])); // R10
   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      susp && $stable(ilv) |-> acc_addr == $past(acc_addr)); // R3
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !ilv && $stable(ilv) |-> acc_addr[BEAT_W-1:0] == $past(acc_addr[BEAT_W-1:0]) + 2'd1); // R4
   AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(standby) && stb_n |-> !acc_vld); // R9
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 64,
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             acc_vld,
   input  logic [AW-1:0]    acc_addr,
   input  logic [LANES-1:0] we_n,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int unsigned LW    = DW / LANES;
   localparam int unsigned DEPTH = 1 << AW;

   logic rd_cyc;
   assign rd_cyc = acc_vld & (&we_n);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (acc_vld && !we_n[l])
            mem[acc_addr] <= wdata[l*LW +: LW];
         if (rd_cyc)
            rdata[l*LW +: LW] <= mem[acc_addr];
      end
   end
endmodule

// File: rtl/bsram_rd_port.sv
module bsram_rd_port #(
   parameter int unsigned DW    = 64,
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_vld,
   input  logic             standby,
   input  logic             oe_n,
   input  logic [LANES-1:0] we_n,
   input  logic [DW-1:0]    rdata,
   output logic [DW-1:0]    dq_out,
   output logic             dq_oe
);
   logic rd_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_pend_q <= 1'b0;
      else
         rd_pend_q <= acc_vld & (&we_n);
   end

   always_comb begin
      dq_oe  = rd_pend_q & ~oe_n & (&we_n) & ~standby;
      dq_out = dq_oe ? rdata : '0;
   end

   AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(&we_n) |-> !dq_oe); // R11
   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe); // R7
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_vld && (&we_n)) && !oe_n && (&we_n) && !standby |-> dq_oe); // R8
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !dq_oe); // R9
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import bsram_pkg::*;
#(
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 64,
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             adr_stb_n,
   input  logic             cnt_en_n,
   input  logic             burst_ilv,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] wr_en_n,
   input  logic [DW-1:0]    wdata,
   input  logic             oe_n,
   output logic [DW-1:0]    dq_out,
   output logic             dq_oe
);
   if (AW <= BEAT_W) begin : g_bad_aw
      $error("AW must exceed the beat field width");
   end
   if (LANES == 0 || (DW % LANES) != 0) begin : g_bad_lanes
      $error("DW must split evenly into LANES");
   end

   logic          acc_vld;
   logic [AW-1:0] acc_addr;
   logic [DW-1:0] rdata;

   bsram_addr_seq #(.AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby  (standby),
      .stb_n    (adr_stb_n),
      .cnt_n    (cnt_en_n),
      .ilv      (burst_ilv),
      .ext_addr (addr),
      .acc_vld  (acc_vld),
      .acc_addr (acc_addr)
   );

   bsram_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
      .clk      (clk),
      .acc_vld  (acc_vld),
      .acc_addr (acc_addr),
      .we_n     (wr_en_n),
      .wdata    (wdata),
      .rdata    (rdata)
   );

   bsram_rd_port #(.DW(DW), .LANES(LANES)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_vld  (acc_vld),
      .standby  (standby),
      .oe_n     (oe_n),
      .we_n     (wr_en_n),
      .rdata    (rdata),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          standby = 1'b0;
   logic          adr_stb_n = 1'b1;
   logic          cnt_en_n = 1'b1;
   logic          burst_ilv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    wr_en_n = 2'b11;
   logic [63:0]   wdata = '0;
   logic          oe_n = 1'b1;
   logic [63:0]   dq_out;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state, derived from the requirements
   logic [63:0]      m_mem [DEPTH];
   logic             m_act = 1'b0, m_pend = 1'b0;
   logic [AW-3:0]    m_hi = '0;
   logic [1:0]       m_start = '0, m_beat = '0;
   logic [63:0]      m_rd = '0;

   always #2 clk = ~clk; // 250 MHz

   burst_sram #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .adr_stb_n(adr_stb_n),
      .cnt_en_n(cnt_en_n), .burst_ilv(burst_ilv), .addr(addr), .wr_en_n(wr_en_n),
      .wdata(wdata), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   function automatic logic [1:0] order_low(input logic [1:0] s, input logic [1:0] k,
                                            input logic il);
      // R4: (s + k) mod 4 ; R5: s XOR k
      return il ? (s ^ k) : (s + k);
   endfunction

   function automatic logic [63:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
      return {salt, 16'h0000, a, ~salt, 16'h5A5A, a};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one cycle of inputs, check outputs, advance the model
   task automatic step(input logic s_n, input logic c_n, input logic [1:0] w_n,
                       input logic il, input logic o_n, input logic sb,
                       input logic [AW-1:0] a, input logic [63:0] d, input string tag);
      logic e_oe, ld, ad, su, acc;
      logic [AW-1:0] ea;
      logic [1:0] nb;
      @(posedge clk);
      #1;
      adr_stb_n = s_n; cnt_en_n = c_n; wr_en_n = w_n; burst_ilv = il;
      oe_n = o_n; standby = sb; addr = a; wdata = d;
      #1;
      e_oe = m_pend & ~o_n & (&w_n) & ~sb;
      check(dq_oe === e_oe, tag, {63'd0, dq_oe}, {63'd0, e_oe});
      if (e_oe)
         check(dq_out === m_rd, tag, dq_out, m_rd);
      if (!(&w_n))
         check(dq_oe === 1'b0, "R11", {63'd0, dq_oe}, 64'd0);
      ld = ~sb & ~s_n;
      ad = ~sb & s_n & ~c_n & m_act;
      su = ~sb & s_n & c_n & m_act;
      acc = ld | ad | su;
      if (ld) begin
         m_hi = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
      end else if (ad) begin
         m_beat = m_beat + 2'd1;
      end
      nb = order_low(m_start, m_beat, il);
      ea = {m_hi, nb};
      if (acc && (&w_n))
         m_rd = m_mem[ea];
      if (acc && !w_n[1]) m_mem[ea][63:32] = d[63:32];
      if (acc && !w_n[0]) m_mem[ea][31:0]  = d[31:0];
      m_pend = acc & (&w_n);
      m_act = ~sb & (ld | m_act);
   endtask

   task automatic idle(input string tag);
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, '0, '0, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] base;
      int unsigned   seed;
      logic          cur_il;
      seed = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: reset state, count-enable without a strobe does nothing
      check(dq_oe === 1'b0, "R12", {63'd0, dq_oe}, 64'd0);
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R12");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R12");

      // fill every word with write bursts (R1 load, R2 advance)
      for (int g = 0; g < DEPTH / 4; g++) begin
         base = AW'(g * 4 + (g % 4));
         step(1'b0, 1'b1, 2'b00, g[2], 1'b1, 1'b0, base, 64'd0, "R1");
         for (int k = 1; k < 4; k++)
            step(1'b1, 1'b0, 2'b00, g[2], 1'b1, 1'b0, '0, 64'd0, "R2");
      end
      // rewrite with the address pattern using single-word strobed writes
      for (int a = 0; a < DEPTH; a++)
         step(1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, AW'(a), pat(AW'(a), 8'h11), "R1");

      // R4 linear burst from start 01 in group 5, plus wrap (R10)
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd21, '0, "R1");
      for (int k = 0; k < 3; k++)
         step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R4");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
      idle("R8");

      // R5 interleaved burst from start 10 at the top group, with wrap
      step(1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 8'd254, '0, "R5");
      for (int k = 0; k < 5; k++)
         step(1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, '0, '0, "R5");
      idle("R8");

      // R3 suspend mid burst, then resume
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd40, '0, "R3");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R3");
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R3");
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R3");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R3");

      // R7 output enable toggled while suspended
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, '0, '0, "R7");
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R7");
      step(1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, '0, '0, "R7");
      idle("R7");

      // R6 half-word writes, then read back
      step(1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 8'd77, 64'hDEAD_BEEF_CAFE_F00D, "R6");
      step(1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 8'd78, 64'h1234_5678_9ABC_DEF0, "R6");
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd77, '0, "R6");
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd78, '0, "R6");
      idle("R6");

      // R11 write right after a read with output enable still low
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd90, '0, "R11");
      step(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'd91, 64'hA1A1_B2B2_C3C3_D4D4, "R11");
      step(1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, '0, 64'h0, "R11");
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd91, '0, "R11");
      idle("R8");

      // R9 standby blocks a write and the output
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd100, '0, "R9");
      step(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 8'd100, 64'hFFFF_0000_FFFF_0000, "R9");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, '0, '0, "R9");
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, '0, '0, "R9");
      step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'd100, '0, "R9");
      idle("R9");

      // seeded random mix (R1 R2 R3 R6 R7 R9 R11)
      cur_il = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         logic s_n, c_n, o_n, sb;
         logic [1:0] w_n;
         s_n = ($urandom % 6) != 0;
         if (!s_n) cur_il = $urandom % 2;
         c_n = ($urandom % 3) == 0;
         w_n = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
         o_n = ($urandom % 4) == 0;
         sb  = ($urandom % 25) == 0;
         step(s_n, c_n, w_n, cur_il, o_n, sb, AW'($urandom), {$urandom, $urandom},
              "R1 R2 R3 R6 R7 R9");
      end
      idle("R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule